// File: doc/BRIEF.md
# Sticky Floating-Point Exception Status Register

This block keeps the exception part of a floating-point status word. An operation-status byte shows the exception flags of the most recent completed operation. An accrued byte keeps a sticky record of the five IEEE 754 exception classes. The arithmetic unit reports each completed operation with a strobe, an eight-bit flag vector and a tag that marks register-move operations. After every operation that is not a move, the block merges the fresh flags into the accrued bits. Each accrued bit follows its own fixed equation over several flags, so the merge is not a plain bit-for-bit OR.

Software reads the whole sixteen-bit word through a combinational read port. It replaces the word through a write strobe, and that write is the normal way to clear the accrued history. A null-state restore strobe and the reset both clear the word. The accrued bits only record status. They never raise or mask a trap.

Top module: `fp_sticky_status`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `rd_data` is 16'h0000.
- R2: The word layout is as follows. `rd_data[15:8]` is the operation-status byte. `rd_data[7:3]` are the accrued bits: bit 7 invalid, bit 6 overflow, bit 5 underflow, bit 4 divide-by-zero, bit 3 inexact. `rd_data[2:0]` always read as zero.
- R3: The flag encoding of `op_flags` is: bit 7 branch-on-NaN, bit 6 signaling NaN, bit 5 operand error, bit 4 overflow, bit 3 underflow, bit 2 divide-by-zero, bit 1 inexact-2, bit 0 inexact-1. On a non-move completion, each accrued bit is ORed with a term. The terms are:
  - invalid: snan | operr.
  - overflow: ovfl.
  - underflow: unfl & inex2.
  - divide-by-zero: dz.
  - inexact: inex1 | inex2 | ovfl.
- R4: On any `op_done` (move or not), the operation-status byte is replaced by `op_flags`.
- R5: When `op_is_move` is high with `op_done`, the accrued bits keep their value.
- R6: An operation completion never clears an accrued bit that is already set.
- R7: `null_restore` clears the whole word, and it takes priority over `op_done`.
- R8: `wr_en` loads `wr_data` into the word, with bits 2:0 forced to zero. No accrual is applied to the written value. The write takes priority over `null_restore` and `op_done` in the same cycle.
- R9: `rd_data` shows the register contents combinationally. A change caused by a strobe appears right after the clock edge that samples it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_done | input | 1 | Operation completion strobe |
| op_is_move | input | 1 | Marks the completing operation as a register move |
| op_flags | input | 8 | Exception flags of the completing operation |
| null_restore | input | 1 | Null-state restore, clears the word |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 16 | Software write data |
| rd_data | output | 16 | Current status word |

## Verification
Each flag is driven alone on a non-move operation, so that every accrual equation is separated from the others. This shows, for example, that underflow alone leaves the accrued underflow bit clear while overflow alone sets two bits. Underflow is then paired with inexact-2 to show the AND term. Move operations carrying every flag show that only the status byte changes. Same-cycle collisions of the write, the restore and the completion strobe fix the priority order. Long random runs without software writes check that the accrued bits only grow.

// File: rtl/fp_sticky_status.sv
module fp_sticky_status (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_done,
  input  logic        op_is_move,
  input  logic [7:0]  op_flags,
  input  logic        null_restore,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data
);

  logic [7:0] exc_q;
  logic [4:0] acc_q;

  logic bsun, snan, operr, ovfl, unfl, dz, inex2, inex1;
  assign {bsun, snan, operr, ovfl, unfl, dz, inex2, inex1} = op_flags;

  logic [4:0] acc_term;
  assign acc_term = { snan | operr,
                      ovfl,
                      unfl & inex2,
                      dz,
                      inex1 | inex2 | ovfl };

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_q <= '0;
      acc_q <= '0;
    end else if (wr_en) begin
      exc_q <= wr_data[15:8];
      acc_q <= wr_data[7:3];
    end else if (null_restore) begin
      exc_q <= '0;
      acc_q <= '0;
    end else if (op_done) begin
      exc_q <= op_flags;
      if (!op_is_move) acc_q <= acc_q | acc_term;
    end
  end

  assign rd_data = {exc_q, acc_q, 3'b000};

endmodule

module fp_sticky_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_done,
  input logic        op_is_move,
  input logic [7:0]  op_flags,
  input logic        null_restore,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data
);

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[2:0] == 3'b000); // R2

  AST_OVFL_ACCRUES: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !op_is_move && op_flags[4] && !wr_en && !null_restore)
      |=> (rd_data[6] && rd_data[3])); // R3

  AST_STATUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !wr_en && !null_restore)
      |=> (rd_data[15:8] == $past(op_flags))); // R4

  AST_MOVE_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && op_is_move && !wr_en && !null_restore)
      |=> $stable(rd_data[7:0])); // R5

  AST_ACC_ONLY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !null_restore)
      |=> ((rd_data[7:3] & $past(rd_data[7:3])) == $past(rd_data[7:3]))); // R6

  AST_RESTORE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (null_restore && !wr_en) |=> (rd_data == 16'h0000)); // R7

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data == {$past(wr_data[15:3]), 3'b000})); // R8

endmodule

bind fp_sticky_status fp_sticky_status_chk u_chk (.*);

// File: tb/fp_sticky_status_bench.sv
module fp_sticky_status_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_done = 1'b0;
  logic        op_is_move = 1'b0;
  logic [7:0]  op_flags = '0;
  logic        null_restore = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;

  fp_sticky_status u_fp_sticky_status (.*);

  always #5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  string req_tag = "R1";
  logic [15:0] model_word = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_word <= '0;
    else begin
      logic [15:0] w;
      w = model_word;
      if (wr_en) w = wr_data & 16'hFFF8;
      else if (null_restore) w = '0;
      else if (op_done) begin
        w[15:8] = op_flags;
        if (!op_is_move) begin
          if (op_flags[6] || op_flags[5]) w[7] = 1'b1;
          if (op_flags[4]) w[6] = 1'b1;
          if (op_flags[3] && op_flags[1]) w[5] = 1'b1;
          if (op_flags[2]) w[4] = 1'b1;
          if (op_flags[1] || op_flags[0] || op_flags[4]) w[3] = 1'b1;
        end
      end
      model_word <= w;
    end
  end

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: rd_data=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) check(rd_data, model_word, req_tag);

  task automatic idle();
    op_done = 0; op_is_move = 0; op_flags = '0; null_restore = 0; wr_en = 0; wr_data = '0;
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic do_op(input logic mv, input logic [7:0] f);
    idle(); op_done = 1; op_is_move = mv; op_flags = f;
    #3 check(rd_data, model_word, {req_tag, "/R9"});
    step(); idle();
  endtask

  task automatic do_wr(input logic [15:0] d);
    idle(); wr_en = 1; wr_data = d; step(); idle();
  endtask

  initial begin
    #2 check(rd_data, 16'h0000, "R1");
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    step();
    check(rd_data, 16'h0000, "R1");

    req_tag = "R3";
    for (int b = 0; b < 8; b++) begin
      do_wr(16'h0000);
      do_op(1'b0, 8'h01 << b);
    end
    do_wr(16'h0000); do_op(1'b0, 8'h08);
    check(rd_data, 16'h0800, "R3");
    do_wr(16'h0000); do_op(1'b0, 8'h0A);
    check(rd_data, 16'h0A28, "R3");
    do_wr(16'h0000); do_op(1'b0, 8'h10);
    check(rd_data, 16'h1048, "R3");

    req_tag = "R4";
    do_op(1'b0, 8'h80);
    check(rd_data[15:8], 16'h0080, "R4");

    req_tag = "R5";
    do_wr(16'h0000);
    do_op(1'b1, 8'hFF);
    check(rd_data, 16'hFF00, "R5");

    req_tag = "R6";
    do_wr(16'h0000);
    for (int i = 0; i < 300; i++) do_op(1'($urandom_range(0, 3) == 0), 8'($urandom));

    req_tag = "R7";
    do_op(1'b0, 8'hFF);
    idle(); null_restore = 1; op_done = 1; op_flags = 8'h7F; step(); idle();
    check(rd_data, 16'h0000, "R7");

    req_tag = "R8";
    do_wr(16'hFFFF);
    check(rd_data, 16'hFFF8, "R2");
    idle(); wr_en = 1; wr_data = 16'h1234; op_done = 1; op_flags = 8'hFF; null_restore = 1;
    step(); idle();
    check(rd_data, 16'h1230, "R8");

    req_tag = "R9";
    for (int i = 0; i < 500; i++) begin
      idle();
      op_done = 1'($urandom_range(0, 1));
      op_is_move = 1'($urandom_range(0, 4) == 0);
      op_flags = 8'($urandom);
      null_restore = 1'($urandom_range(0, 30) == 0);
      wr_en = 1'($urandom_range(0, 20) == 0);
      wr_data = 16'($urandom);
      step();
    end
    idle(); step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1000000;
    compared++; mismatched++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule